// File: doc/BRIEF.md
# Frame-Level Search Window Reuse Scheduler

This controller orders the work of a multi-reference motion estimation engine so that every reference search window is brought in from system memory a single time. Once the window of reference frame r at macroblock position m is resident, the scheduler walks through the current macroblocks at position m in the later frames r+1, r+2 and so on. It issues one estimate command for each of them, up to `MAX_REF` frames ahead. Only then does it move on to the next window. Because the loops are nested this way, a current macroblock is fetched once per reference frame it searches, while a window is never fetched twice.

Frames are numbered 0 to `num_frames`-1. Frame 0 serves only as a reference, and frames 1 and up are predicted. Windows are taken in order of reference frame, and inside one reference frame in order of macroblock position. Each estimate command carries a step number, which is the distance between the current frame and the reference frame. A frame close to the start of the sequence has fewer than `MAX_REF` earlier frames, so it only receives the steps whose reference frame exists. With this ordering, the last step any current macroblock receives is always step 1 (reference = current frame minus one). When that step reports done, the scheduler emits a one-cycle completion pulse that names the macroblock, so that final mode decision for it can start.

Top module: `fwr_sched`

## Requirements
- R1: While reset is asserted and after it is released, `ld_req`, `est_req` and `cmp_vld` are low until a run is started.
- R2: A `start` pulse while idle begins a run, but only if `num_frames` >= 2 and `num_mbs` >= 1; otherwise no request is issued. A `start` pulse while a run is in progress has no effect on the command sequence.
- R3: Window loads are issued for reference frames 0 to `num_frames`-2, with the reference frame as the outer order and the macroblock position 0 to `num_mbs`-1 as the inner order. Each window (reference, position) is loaded exactly once.
- R4: After the window (r, m) is loaded, estimate commands follow for the current frames r+1, r+2, ..., r+K at position m, in increasing frame order, where K = min(`MAX_REF`, `num_frames`-1-r). Each command carries `est_step` = current frame minus r.
- R5: A load or estimate request stays high, with its fields unchanged, until its done input is seen high at a clock edge. The following command is presented no earlier than the next cycle.
- R6: A new window load is issued only after the done of the last estimate on the previous window.
- R7: One cycle after the done of an estimate with step 1, `cmp_vld` pulses for one cycle with `cmp_frame` = r+1 and `cmp_mb` = m of that estimate. No other pulse occurs. Each predicted macroblock therefore completes exactly once, after all of its steps.
- R8: With `MAX_REF` = 4, six positions and six frames (five predicted), a run issues 30 loads, 84 estimates and 30 completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run using the counts below |
| num_frames | input | FRM_W | Total frames in the sequence, including frame 0 |
| num_mbs | input | MB_W | Macroblock positions per frame |
| ld_req | output | 1 | Window load request |
| ld_ref | output | FRM_W | Reference frame of the window to load |
| ld_mb | output | MB_W | Macroblock position of the window |
| ld_done | input | 1 | Load finished |
| est_req | output | 1 | Estimate request |
| est_frame | output | FRM_W | Current frame to fetch and search |
| est_mb | output | MB_W | Current macroblock position |
| est_step | output | STEP_W | Distance from the current frame to the reference frame |
| est_done | input | 1 | Estimate finished and partial results written |
| cmp_vld | output | 1 | Macroblock has finished all of its steps |
| cmp_frame | output | FRM_W | Frame of the finished macroblock |
| cmp_mb | output | MB_W | Position of the finished macroblock |

## Verification
The bench goes after short sequences such as two or three frames, where the step limit is the frame count and not `MAX_REF`. A design that clamped wrongly there would issue estimates for frames past the end or would skip the last frame. Single-position runs test whether the scheduler wraps the position and advances the reference frame at the right time; a wrong wrap shows up as a reloaded or missing window, which the duplicate-load tracking reports. Stray `start` pulses during a run, and starts with zero positions or a single frame, expose a controller that restarts or launches an empty sweep. Completion pulses are matched one by one, so a design that signalled completion on the first step instead of the last would be flagged.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_EST  = 2'd2
    } fwr_state_e;
endpackage

// File: rtl/fwr_step_limit.sv
module fwr_step_limit #(
    parameter int MAX_REF = 4,
    parameter int FRM_W   = 8,
    localparam int STEP_W = $clog2(MAX_REF + 1)
) (
    input  logic [FRM_W-1:0]  frames,
    input  logic [FRM_W-1:0]  ref_idx,
    output logic [STEP_W-1:0] kmax
);
    logic [FRM_W-1:0] avail;

    always_comb begin
        // frames still ahead of this reference frame
        avail = frames - ref_idx - FRM_W'(1);
        if (avail > FRM_W'(MAX_REF))
            kmax = STEP_W'(MAX_REF);
        else
            kmax = STEP_W'(avail);
    end
endmodule

// File: rtl/fwr_last_flags.sv
module fwr_last_flags #(
    parameter int MAX_REF = 4,
    parameter int FRM_W   = 8,
    parameter int MB_W    = 12,
    localparam int STEP_W = $clog2(MAX_REF + 1)
) (
    input  logic [FRM_W-1:0]  frames,
    input  logic [MB_W-1:0]   mbs,
    input  logic [FRM_W-1:0]  ref_idx,
    input  logic [MB_W-1:0]   mb_idx,
    input  logic [STEP_W-1:0] step,
    input  logic [STEP_W-1:0] kmax,
    output logic              last_step,
    output logic              last_mb,
    output logic              last_ref
);
    always_comb begin
        last_step = (step >= kmax);
        last_mb   = (mb_idx == mbs - MB_W'(1));
        last_ref  = (ref_idx == frames - FRM_W'(2));
    end
endmodule

// File: rtl/fwr_sched.sv
module fwr_sched
    import fwr_pkg::*;
#(
    parameter int MAX_REF = 4,
    parameter int FRM_W   = 8,
    parameter int MB_W    = 12,
    localparam int STEP_W = $clog2(MAX_REF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FRM_W-1:0]  num_frames,
    input  logic [MB_W-1:0]   num_mbs,
    output logic              ld_req,
    output logic [FRM_W-1:0]  ld_ref,
    output logic [MB_W-1:0]   ld_mb,
    input  logic              ld_done,
    output logic              est_req,
    output logic [FRM_W-1:0]  est_frame,
    output logic [MB_W-1:0]   est_mb,
    output logic [STEP_W-1:0] est_step,
    input  logic              est_done,
    output logic              cmp_vld,
    output logic [FRM_W-1:0]  cmp_frame,
    output logic [MB_W-1:0]   cmp_mb
);
    typedef struct packed {
        fwr_state_e        st;
        logic [FRM_W-1:0]  ref_idx;
        logic [MB_W-1:0]   mb_idx;
        logic [STEP_W-1:0] step;
        logic [FRM_W-1:0]  nf;
        logic [MB_W-1:0]   nm;
        logic              cv;
        logic [FRM_W-1:0]  cf;
        logic [MB_W-1:0]   cm;
    } regs_t;

    regs_t r_d, r_q;

    logic [STEP_W-1:0] kmax;
    logic              last_step, last_mb, last_ref;

    fwr_step_limit #(.MAX_REF(MAX_REF), .FRM_W(FRM_W)) u_limit (
        .frames  (r_q.nf),
        .ref_idx (r_q.ref_idx),
        .kmax    (kmax)
    );

    fwr_last_flags #(.MAX_REF(MAX_REF), .FRM_W(FRM_W), .MB_W(MB_W)) u_flags (
        .frames    (r_q.nf),
        .mbs       (r_q.nm),
        .ref_idx   (r_q.ref_idx),
        .mb_idx    (r_q.mb_idx),
        .step      (r_q.step),
        .kmax      (kmax),
        .last_step (last_step),
        .last_mb   (last_mb),
        .last_ref  (last_ref)
    );

    always_comb begin
        r_d    = r_q;
        r_d.cv = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start && (num_frames >= FRM_W'(2)) && (num_mbs != '0)) begin
                    r_d.nf      = num_frames;
                    r_d.nm      = num_mbs;
                    r_d.ref_idx = '0;
                    r_d.mb_idx  = '0;
                    r_d.step    = '0;
                    r_d.st      = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (ld_done) begin
                    r_d.step = STEP_W'(1);
                    r_d.st   = ST_EST;
                end
            end
            ST_EST: begin
                if (est_done) begin
                    if (r_q.step == STEP_W'(1)) begin
                        r_d.cv = 1'b1;
                        r_d.cf = r_q.ref_idx + FRM_W'(1);
                        r_d.cm = r_q.mb_idx;
                    end
                    if (!last_step) begin
                        r_d.step = r_q.step + STEP_W'(1);
                    end else if (!last_mb) begin
                        r_d.mb_idx = r_q.mb_idx + MB_W'(1);
                        r_d.st     = ST_LOAD;
                    end else if (!last_ref) begin
                        r_d.mb_idx  = '0;
                        r_d.ref_idx = r_q.ref_idx + FRM_W'(1);
                        r_d.st      = ST_LOAD;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ld_req    = (r_q.st == ST_LOAD);
    assign ld_ref    = r_q.ref_idx;
    assign ld_mb     = r_q.mb_idx;
    assign est_req   = (r_q.st == ST_EST);
    assign est_frame = r_q.ref_idx + FRM_W'(r_q.step);
    assign est_mb    = r_q.mb_idx;
    assign est_step  = r_q.step;
    assign cmp_vld   = r_q.cv;
    assign cmp_frame = r_q.cf;
    assign cmp_mb    = r_q.cm;

    // R5
    ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_done) |=> (ld_req && $stable(ld_ref) && $stable(ld_mb)));

    // R5
    est_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est_req && !est_done) |=> (est_req && $stable(est_frame) && $stable(est_step)));

    // R6
    ld_after_est_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !$past(ld_req)) |-> $past(est_done || start));

    // R4
    est_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        est_req |-> ((est_step != '0) && (est_step <= STEP_W'(MAX_REF)) && (est_frame < r_q.nf)));

    // R7
    cmp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_vld |-> $past(est_req && est_done && (est_step == STEP_W'(1))));
endmodule

// File: tb/fwr_sched_tb.sv
module fwr_sched_tb;
    localparam int MAX_REF = 4;
    localparam int FRM_W   = 8;
    localparam int MB_W    = 12;
    localparam int STEP_W  = $clog2(MAX_REF + 1);
    localparam int LIMIT   = 150000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic [FRM_W-1:0]  num_frames;
    logic [MB_W-1:0]   num_mbs;
    logic              ld_req, ld_done;
    logic [FRM_W-1:0]  ld_ref;
    logic [MB_W-1:0]   ld_mb;
    logic              est_req, est_done;
    logic [FRM_W-1:0]  est_frame;
    logic [MB_W-1:0]   est_mb;
    logic [STEP_W-1:0] est_step;
    logic              cmp_vld;
    logic [FRM_W-1:0]  cmp_frame;
    logic [MB_W-1:0]   cmp_mb;

    fwr_sched #(.MAX_REF(MAX_REF), .FRM_W(FRM_W), .MB_W(MB_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .num_frames(num_frames), .num_mbs(num_mbs),
        .ld_req(ld_req), .ld_ref(ld_ref), .ld_mb(ld_mb), .ld_done(ld_done),
        .est_req(est_req), .est_frame(est_frame), .est_mb(est_mb),
        .est_step(est_step), .est_done(est_done),
        .cmp_vld(cmp_vld), .cmp_frame(cmp_frame), .cmp_mb(cmp_mb)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit is_ld;
        int a;
        int b;
        int c;
    } cmd_t;

    cmd_t exp_cmd[$];
    cmd_t exp_cmp[$];
    bit   seen_win[int];
    int   checks = 0;
    int   errors = 0;
    int   cyc    = 0;
    bit   timed_out = 0;
    int   n_ld, n_est, n_cmp;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic int min_i(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    task automatic build_expect(input int f, input int m);
        cmd_t c;
        exp_cmd.delete();
        exp_cmp.delete();
        seen_win.delete();
        for (int r = 0; r <= f - 2; r++) begin
            for (int mm = 0; mm < m; mm++) begin
                c.is_ld = 1; c.a = r; c.b = mm; c.c = 0;
                exp_cmd.push_back(c);
                for (int k = 1; k <= min_i(MAX_REF, f - 1 - r); k++) begin
                    c.is_ld = 0; c.a = r + k; c.b = mm; c.c = k;
                    exp_cmd.push_back(c);
                end
                c.is_ld = 0; c.a = r + 1; c.b = mm; c.c = 0;
                exp_cmp.push_back(c);
            end
        end
    endtask

    task automatic run_case(input int f, input int m);
        int dly;
        cmd_t e;
        build_expect(f, m);
        n_ld = 0; n_est = 0; n_cmp = 0;
        @(negedge clk);
        num_frames = FRM_W'(f);
        num_mbs    = MB_W'(m);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: first command is the load of window (0,0)
        chk(ld_req && ld_ref == 0 && ld_mb == 0, "R2",
            $sformatf("first load req=%0b ref=%0d mb=%0d exp 1/0/0", ld_req, ld_ref, ld_mb));
        dly = $urandom % 4;
        while ((exp_cmd.size() != 0 || exp_cmp.size() != 0) && !timed_out) begin
            if (cyc > LIMIT) begin
                timed_out = 1;
                break;
            end
            if (cmp_vld) begin
                n_cmp++;
                if (exp_cmp.size() == 0) begin
                    chk(0, "R7", $sformatf("extra completion %0d/%0d exp none", cmp_frame, cmp_mb));
                end else begin
                    e = exp_cmp.pop_front();
                    chk(cmp_frame == e.a && cmp_mb == e.b, "R7",
                        $sformatf("completion %0d/%0d exp %0d/%0d", cmp_frame, cmp_mb, e.a, e.b));
                end
            end
            if (ld_req || est_req) begin
                if (dly > 0) begin
                    dly--;
                end else if (exp_cmd.size() == 0) begin
                    chk(0, "R3", $sformatf("unexpected request ld=%0b est=%0b exp none", ld_req, est_req));
                    ld_done  = ld_req;
                    est_done = est_req;
                end else begin
                    e = exp_cmd.pop_front();
                    if (ld_req) begin
                        n_ld++;
                        chk(e.is_ld && ld_ref == e.a && ld_mb == e.b, "R3",
                            $sformatf("load %0d/%0d exp ld=%0b %0d/%0d", ld_ref, ld_mb, e.is_ld, e.a, e.b));
                        chk(!seen_win.exists(int'(ld_ref) * 4096 + int'(ld_mb)), "R3",
                            $sformatf("window %0d/%0d loaded twice exp once", ld_ref, ld_mb));
                        seen_win[int'(ld_ref) * 4096 + int'(ld_mb)] = 1;
                        ld_done = 1'b1;
                    end else begin
                        n_est++;
                        chk(!e.is_ld && est_frame == e.a && est_mb == e.b && est_step == e.c, "R4",
                            $sformatf("est %0d/%0d s%0d exp ld=%0b %0d/%0d s%0d",
                                      est_frame, est_mb, est_step, e.is_ld, e.a, e.b, e.c));
                        est_done = 1'b1;
                    end
                    dly = $urandom % 4;
                end
            end
            // R2: stray start while running must be ignored
            start = (exp_cmd.size() != 0) && (($urandom % 8) == 0);
            @(negedge clk);
            ld_done  = 1'b0;
            est_done = 1'b0;
            start    = 1'b0;
            // R5/R6: done released the request; both never together
            chk(!(ld_req && est_req), "R5", "load and estimate requests both high exp exclusive");
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!ld_req && !est_req && !cmp_vld, "R3",
                $sformatf("activity after run ld=%0b est=%0b cmp=%0b exp 0", ld_req, est_req, cmp_vld));
        end
    endtask

    task automatic reject_case(input int f, input int m);
        @(negedge clk);
        num_frames = FRM_W'(f);
        num_mbs    = MB_W'(m);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!ld_req && !est_req && !cmp_vld, "R2",
                $sformatf("start with frames=%0d mbs=%0d gave ld=%0b est=%0b exp 0", f, m, ld_req, est_req));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; ld_done = 1'b0; est_done = 1'b0;
        num_frames = '0; num_mbs = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk(!ld_req && !est_req && !cmp_vld, "R1", "outputs active in reset exp 0");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ld_req && !est_req && !cmp_vld, "R1", "outputs active after reset exp 0");

        reject_case(1, 3);
        reject_case(4, 0);
        reject_case(0, 2);

        // R8: six positions, five predicted frames
        run_case(6, 6);
        chk(n_ld == 30, "R8", $sformatf("loads %0d exp 30", n_ld));
        chk(n_est == 84, "R8", $sformatf("estimates %0d exp 84", n_est));
        chk(n_cmp == 30, "R8", $sformatf("completions %0d exp 30", n_cmp));

        run_case(2, 1);
        run_case(3, 2);
        run_case(5, 1);
        for (int t = 0; t < 8 && !timed_out; t++) begin
            run_case(2 + int'($urandom % 8), 1 + int'($urandom % 5));
        end

        if (timed_out) chk(0, "R3", "watchdog expired exp run to finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule